// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Unit with Overflow Detection

This combinational unit adds or subtracts two 32-bit two's-complement values in a single pass. The second operand comes either from a full-width register input or from a 16-bit immediate. The immediate is always sign-extended, whichever variant is selected. Subtraction uses the same adder: the second operand is inverted and a carry-in of one is applied.

The unit has two status outputs. A signed-overflow flag is decided purely from the signs of the operands and of the result. The unsigned carry-out is reported separately. An exception request is raised only when the trapping select is active and overflow has occurred. The non-trapping variants therefore produce the same sum and flags but never ask for an exception. Only the request line is produced here; vectoring and return-address handling belong elsewhere.

Top module: `addsub_ovf`

## Requirements
- R1: With sub_i = 0, result_o equals operand A plus the selected operand B, modulo 2^32.
- R2: With sub_i = 1, result_o equals A plus the bitwise inverse of the selected B plus 1, i.e. A minus B modulo 2^32.
- R3: With use_imm_i = 1, the selected B is imm_i with bit 15 copied into bits 31:16. This holds for trapping and non-trapping variants alike.
- R4: On an add, ovf_o is 1 exactly when A and B share a sign bit and result_o has the other sign bit.
- R5: On a subtract, ovf_o is 1 exactly when A and B differ in sign bit and result_o's sign bit differs from A's.
- R6: An add of operands with different sign bits, or a subtract of operands with equal sign bits, never sets ovf_o.
- R7: carry_o is the unsigned carry out of bit 31. It is 1 on an add when A+B ≥ 2^32, and 1 on a subtract when A ≥ B as unsigned values. It does not alter ovf_o.
- R8: exc_o equals ovf_o AND trap_en_i. With trap_en_i = 0, exc_o stays 0 for every operand.
- R9: The unselected operand source has no effect: b_i is ignored when use_imm_i = 1, and imm_i is ignored when use_imm_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate operand, sign-extended when selected |
| use_imm_i | input | 1 | 1 selects the immediate as B |
| sub_i | input | 1 | 0 adds, 1 subtracts |
| trap_en_i | input | 1 | 1 for trapping variants |
| result_o | output | 32 | Sum or difference |
| carry_o | output | 1 | Unsigned carry out of the top bit |
| ovf_o | output | 1 | Signed overflow flag |
| exc_o | output | 1 | Exception request |

## Verification
The embedded assertions re-derive the following on every evaluation, using arithmetic wider than the datapath:
- the sum or difference;
- the signed overflow;
- the sign-extension of the immediate;
- the gating of the exception request;
- the fact that opposite-sign adds and same-sign subtracts never overflow.

Some behaviours can only be shown by the bench's scenarios:
- the unsigned carry matching an unsigned compare;
- the unselected source being ignored;
- the exact boundary pairs around the most negative and most positive values, such as subtracting the most negative value from zero.

// File: rtl/addsub_ovf.sv
module addsub_ovf #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sub_i,
  input  logic             trap_en_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             exc_o
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  logic [W-1:0] opnd_b;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_w;

  assign imm_ext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign opnd_b   = use_imm_i ? imm_ext : b_i;
  assign b_eff    = sub_i ? ~opnd_b : opnd_b;
  assign sum_w    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign result_o = sum_w[W-1:0];
  assign carry_o  = sum_w[W];
  assign ovf_o    = (a_i[W-1] == b_eff[W-1]) && (result_o[W-1] != a_i[W-1]);
  assign exc_o    = ovf_o & trap_en_i;

  logic signed [W+1:0] ref_wide;
  logic                ref_ovf;
  always_comb begin
    ref_wide = sub_i ? ($signed({{2{a_i[W-1]}}, a_i}) - $signed({{2{opnd_b[W-1]}}, opnd_b}))
                     : ($signed({{2{a_i[W-1]}}, a_i}) + $signed({{2{opnd_b[W-1]}}, opnd_b}));
    ref_ovf  = ref_wide[W] != ref_wide[W-1];
  end

  always_comb begin
    // R1 R2
    result_chk: assert (result_o == ref_wide[W-1:0])
      else $error("result mismatch");
    // R4 R5
    signed_ovf_chk: assert (ovf_o == ref_ovf)
      else $error("overflow mismatch");
    // R3
    sext_chk: assert (!use_imm_i || opnd_b[W-1:IMM_W] == {EXT_W{imm_i[IMM_W-1]}})
      else $error("immediate not sign-extended");
    // R6
    no_overflow_chk: assert (!((a_i[W-1] != opnd_b[W-1]) ^ sub_i) || !ovf_o)
      else $error("overflow where impossible");
    // R8
    exc_gate_chk: assert (exc_o == (ovf_o && trap_en_i))
      else $error("exception request not gated");
  end
endmodule

// File: tb/addsub_ovf_tb.sv
module addsub_ovf_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic use_imm, sub, trap, cy, ovf, exc;

  addsub_ovf u_dut (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .sub_i(sub),
    .trap_en_i(trap), .result_o(res), .carry_o(cy), .ovf_o(ovf), .exc_o(exc)
  );

  typedef struct {
    logic [31:0] r;
    logic c, o, e;
    string tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;

  task automatic push(input logic [31:0] ta, input logic [31:0] tb, input logic [15:0] ti,
                      input logic tu, input logic ts, input logic tt, input string tag);
    exp_t x;
    logic [31:0] bsel;
    longint sa, sb, sr;
    @(posedge clk);
    #1;
    a = ta; b = tb; imm = ti; use_imm = tu; sub = ts; trap = tt;
    bsel = tu ? {{16{ti[15]}}, ti} : tb;
    sa = longint'($signed(ta));
    sb = longint'($signed(bsel));
    sr = ts ? sa - sb : sa + sb;
    x.r = sr[31:0];
    x.o = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    x.c = ts ? (ta >= bsel) : ((64'(ta) + 64'(bsel)) > 64'hFFFF_FFFF);
    x.e = x.o && tt;
    x.tag = tag;
    q.push_back(x);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        x = q.pop_front();
        compared++;
        if (res !== x.r || cy !== x.c || ovf !== x.o || exc !== x.e) begin
          mismatched++;
          $display("FAIL %s: got r=%h c=%b o=%b e=%b expected r=%h c=%b o=%b e=%b",
                   x.tag, res, cy, ovf, exc, x.r, x.c, x.o, x.e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    a = '0; b = '0; imm = '0; use_imm = 0; sub = 0; trap = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    push(32'h0, 32'h0, 16'h0, 0, 0, 1, "R1 idle zero");
    push(32'd5, 32'd7, 16'h0, 0, 0, 1, "R1 small add");
    push(32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 1, "R4 maxint+1 overflow");
    push(32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 0, 0, 1, "R4 minint-1 overflow carry R7");
    push(32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 0, "R8 non-trapping add no exception");
    push(32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, 0, 1, "R6 opposite-sign add");
    push(32'd3, 32'd10, 16'h0, 0, 1, 1, "R2 small subtract borrow R7");
    push(32'd0, 32'h8000_0000, 16'h0, 0, 1, 1, "R5 zero minus minint");
    push(32'h8000_0000, 32'd1, 16'h0, 0, 1, 1, "R5 minint minus one");
    push(32'h8000_0000, 32'h8000_0000, 16'h0, 0, 1, 1, "R6 same-sign subtract");
    push(32'h8000_0000, 32'd1, 16'h0, 0, 1, 0, "R8 non-trapping subtract");
    push(32'd100, 32'hDEAD_BEEF, 16'h8000, 1, 0, 0, "R3 R9 unsigned-add immediate sign-extended");
    push(32'd100, 32'h0, 16'hFFFF, 1, 0, 1, "R3 immediate minus one");
    push(32'h8000_0000, 32'h1234_5678, 16'hFFFF, 1, 0, 1, "R4 R9 immediate overflow");
    push(32'd50, 32'd20, 16'h7FFF, 0, 1, 1, "R9 immediate ignored");
    push(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 1, 1, "R7 equal subtract carry set");
    for (int i = 0; i < 300; i++)
      push($urandom, $urandom, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           "R1 R2 R4 R5 R8 random");
    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R1 drain: got %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule